// File: doc/BRIEF.md
# Three-Wire Wiper Position Controller

This block is the digital side of a stepped potentiometer. A host drives three lines: an active-low select, a direction line and a step line. Each high-to-low transition of the step line, while the block is selected, moves a wiper position counter up or down by one tap. The counter covers 100 taps and stops at both ends. Its value is decoded into a registered one-hot tap select that drives the analog switches. The switches themselves lie outside this block.

A parameterised register with a write busy period stands in for the nonvolatile store. When the host releases the select line with the step line high, the position is saved. Releasing it with the step line low keeps the live position and leaves the stored one untouched. Every reset acts as a power-up. The counter reloads from the stored value, and steps are refused until a settle delay has run and the ready flag is high. All three inputs are synchronised with two flops into the single clock domain, and edges are detected on the synchronised copies.

Top module: `wiper_ctrl`

## Requirements
- R1: On reset, `wiper_pos` takes the stored value. `recall_done` is 0 after reset and goes to 1 once `SETTLE_CYCLES` cycles have passed.
- R2: The position changes only on a falling edge of `inc` while `cs_n` is low. A rising edge of `inc`, or any edge of `inc` while `cs_n` is high, leaves the position unchanged.
- R3: At a step, `up_dn` = 1 adds one and `up_dn` = 0 subtracts one. `up_dn` may change between steps while `cs_n` stays low.
- R4: The position stays within 0..NUM_TAPS-1. A step up at the top tap or a step down at 0 leaves it unchanged. It never wraps.
- R5: A rising edge of `cs_n` while `inc` is high writes the current position into the stored register, and a later reset recalls that value.
- R6: A rising edge of `cs_n` while `inc` is low writes nothing. A later reset recalls the earlier stored value.
- R7: Falling edges of `inc` before `recall_done` is 1 do not move the position.
- R8: After a store, `store_busy` is high for exactly `STORE_CYCLES` cycles. Select and step activity during that time moves nothing and starts no further write.
- R9: `tap_sel` has exactly one bit set outside reset, and bit k is set when `wiper_pos` is k, one cycle after the position changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, treated as a power cycle |
| cs_n | input | 1 | Active-low select, asynchronous to clk |
| up_dn | input | 1 | Step direction, 1 = up, asynchronous to clk |
| inc | input | 1 | Step line, falling edge steps, asynchronous to clk |
| tap_sel | output | NUM_TAPS | One-hot tap switch select |
| wiper_pos | output | $clog2(NUM_TAPS) | Current wiper position |
| store_busy | output | 1 | High while a store is in progress |
| recall_done | output | 1 | High once the power-up settle delay has run |

## Verification
A corrupted counter shows up three clock edges after the step that caused it, as a wrong `wiper_pos`. It shows up one edge later as a misplaced or duplicated `tap_sel` bit. A lost or spurious store cannot be seen until the next reset, so each store and each non-store exit is followed by a reset, and the recalled position is compared. A wrong busy length shows directly as a miscount of `store_busy` cycles. A select edge that is not properly ignored during the busy period appears as a position change once the busy period ends.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_RUN    = 2'd1,
    ST_WRITE  = 2'd2
  } wiper_state_e;
endpackage

// File: rtl/wiper_sync.sv
// Two-flop synchronizer, one chain per input bit.
module wiper_sync #(
  parameter int            WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_LVL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_chain
      logic meta_q, sync_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= RST_LVL[g];
          sync_q <= RST_LVL[g];
        end else begin
          meta_q <= din[g];
          sync_q <= meta_q;
        end
      end
      assign lvl[g] = sync_q;
    end
  endgenerate
endmodule

// File: rtl/wiper_nvreg.sv
// Model of the nonvolatile position store: content survives reset, and each write holds busy.
module wiper_nvreg #(
  parameter int POS_W        = 7,
  parameter int STORE_CYCLES = 2500000,
  parameter int NV_INIT      = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [POS_W-1:0] wr_data,
  output logic [POS_W-1:0] rd_data,
  output logic             busy
);
  localparam int CNT_W = $clog2(STORE_CYCLES + 1);

  logic [POS_W-1:0] mem_q = POS_W'(NV_INIT);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (wr_en && !busy_q) mem_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (wr_en && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(STORE_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign rd_data = mem_q;
  assign busy    = busy_q;

  p_write_sets_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy_q) |=> (busy_q && mem_q == $past(wr_data)));
endmodule

// File: rtl/wiper_decode.sv
// Registered position-to-one-hot decoder driving the tap switches.
module wiper_decode #(
  parameter int NUM_TAPS = 100,
  parameter int POS_W    = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [POS_W-1:0]    pos,
  output logic [NUM_TAPS-1:0] sel
);
  logic [NUM_TAPS-1:0] sel_q;

  genvar g;
  generate
    for (g = 0; g < NUM_TAPS; g++) begin : g_tap
      always_ff @(posedge clk) begin
        if (rst) sel_q[g] <= 1'b0;
        else     sel_q[g] <= (pos == POS_W'(g));
      end
    end
  endgenerate

  assign sel = sel_q;

  p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(sel_q) == 1));
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int NUM_TAPS      = 100,
  parameter int STORE_CYCLES  = 2500000,
  parameter int SETTLE_CYCLES = 62500,
  parameter int NV_INIT       = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cs_n,
  input  logic                        up_dn,
  input  logic                        inc,
  output logic [NUM_TAPS-1:0]         tap_sel,
  output logic [$clog2(NUM_TAPS)-1:0] wiper_pos,
  output logic                        store_busy,
  output logic                        recall_done
);
  localparam int POS_W = $clog2(NUM_TAPS);
  localparam int TOP   = NUM_TAPS - 1;
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1);

  // Synchronised input levels: bit 2 select, bit 1 direction, bit 0 step.
  logic [2:0] lvl;
  wiper_sync #(.WIDTH(3), .RST_LVL(3'b111)) u_sync (
    .clk(clk), .rst(rst), .din({cs_n, up_dn, inc}), .lvl(lvl)
  );

  logic cs_d, inc_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b1;
      inc_d <= 1'b1;
    end else begin
      cs_d  <= lvl[2];
      inc_d <= lvl[0];
    end
  end

  logic selected, cs_rise, inc_fall, inc_high, dir_up;
  assign selected = ~lvl[2];
  assign cs_rise  = lvl[2] & ~cs_d;
  assign inc_fall = inc_d & ~lvl[0];
  assign inc_high = lvl[0];
  assign dir_up   = lvl[1];

  wiper_state_e     state_q;
  logic [POS_W-1:0] pos_q;
  logic [SET_W-1:0] settle_q;
  logic             ready_q;
  logic             wr_en, nv_busy;
  logic [POS_W-1:0] nv_rd;
  logic [POS_W-1:0] pos_step;

  assign wr_en = (state_q == ST_RUN) && cs_rise && inc_high;

  always_comb begin
    pos_step = pos_q;
    if (dir_up) begin
      if (pos_q != POS_W'(TOP)) pos_step = pos_q + 1'b1;
    end else begin
      if (pos_q != '0) pos_step = pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_SETTLE;
      pos_q    <= nv_rd;
      settle_q <= '0;
      ready_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SETTLE: begin
          if (settle_q == SET_W'(SETTLE_CYCLES - 1)) begin
            ready_q <= 1'b1;
            state_q <= ST_RUN;
          end else begin
            settle_q <= settle_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (wr_en)                     state_q <= ST_WRITE;
          else if (selected && inc_fall) pos_q   <= pos_step;
        end
        ST_WRITE: begin
          if (!nv_busy) state_q <= ST_RUN;
        end
        default: state_q <= ST_SETTLE;
      endcase
    end
  end

  wiper_nvreg #(.POS_W(POS_W), .STORE_CYCLES(STORE_CYCLES), .NV_INIT(NV_INIT)) u_nv (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(pos_q), .rd_data(nv_rd), .busy(nv_busy)
  );

  wiper_decode #(.NUM_TAPS(NUM_TAPS), .POS_W(POS_W)) u_dec (
    .clk(clk), .rst(rst), .pos(pos_q), .sel(tap_sel)
  );

  assign wiper_pos   = pos_q;
  assign store_busy  = nv_busy;
  assign recall_done = ready_q;

  p_pos_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    pos_q <= POS_W'(TOP));
  p_no_wrap_top_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && selected && inc_fall && dir_up && !cs_rise && pos_q == POS_W'(TOP))
      |=> pos_q == POS_W'(TOP));
  p_no_wrap_bottom_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && selected && inc_fall && !dir_up && pos_q == '0) |=> pos_q == '0);
  p_quiet_without_step_r2: assert property (@(posedge clk) disable iff (rst)
    !inc_fall |=> $stable(pos_q));
  p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !ready_q |=> $stable(pos_q));
  p_busy_only_writing_r8: assert property (@(posedge clk) disable iff (rst)
    nv_busy |-> (state_q == ST_WRITE));
  p_hold_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
    nv_busy |=> $stable(pos_q));
endmodule

// File: tb/test_wiper_ctrl.sv
`timescale 1ns/1ps
module test_wiper_ctrl;
  localparam int TAPS   = 100;
  localparam int STORE  = 20;
  localparam int SETTLE = 10;
  localparam int INIT   = 37;
  localparam int PW     = $clog2(TAPS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, up_dn = 1'b1, inc = 1'b1;
  logic [TAPS-1:0] tap_sel;
  logic [PW-1:0]   wiper_pos;
  logic            store_busy, recall_done;

  int n_checks = 0, n_errs = 0;
  int exp_pos;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wiper_ctrl #(.NUM_TAPS(TAPS), .STORE_CYCLES(STORE), .SETTLE_CYCLES(SETTLE), .NV_INIT(INIT))
    i_wiper_ctrl (.clk(clk), .rst(rst), .cs_n(cs_n), .up_dn(up_dn), .inc(inc),
                  .tap_sel(tap_sel), .wiper_pos(wiper_pos), .store_busy(store_busy),
                  .recall_done(recall_done));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_pos(input string req);
    logic [TAPS-1:0] want;
    want = TAPS'(1) << exp_pos;
    check(int'(wiper_pos) == exp_pos, req, int'(wiper_pos), exp_pos);
    n_checks++;
    if (tap_sel !== want) begin
      n_errs++;
      $display("FAIL R9 tap_sel actual=%h expected=%h", tap_sel, want);
    end
  endtask

  function automatic int model_step(input int p, input bit up);
    if (up) return (p < TAPS - 1) ? p + 1 : p;
    return (p > 0) ? p - 1 : p;
  endfunction

  // One step pulse while selected.
  task automatic step(input bit up, input string req);
    up_dn = up;
    wait_cyc(4);
    inc = 1'b0;
    wait_cyc(5);
    inc = 1'b1;
    wait_cyc(5);
    exp_pos = model_step(exp_pos, up);
    check_pos(req);
  endtask

  task automatic power_cycle();
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    int busy_cnt;
    int saved;
    // R1: reset recalls the initial stored value, ready stays low.
    cs_n = 1'b0;
    wait_cyc(3);
    check(int'(wiper_pos) == INIT, "R1 recall during reset", int'(wiper_pos), INIT);
    rst = 1'b0;
    exp_pos = INIT;
    wait_cyc(1);
    check(recall_done == 1'b0, "R1 ready low after reset", int'(recall_done), 0);
    // R7: step attempt before ready is ignored.
    inc = 1'b0;
    wait_cyc(2);
    inc = 1'b1;
    wait_cyc(2);
    check(recall_done == 1'b0, "R7 still settling", int'(recall_done), 0);
    check(int'(wiper_pos) == INIT, "R7 no step before ready", int'(wiper_pos), INIT);
    wait_cyc(SETTLE + 4);
    check(recall_done == 1'b1, "R1 ready after settle", int'(recall_done), 1);
    check_pos("R7 position after settle");

    // R3/R4: upward sweep into the top end, then downward sweep into zero.
    for (int i = 0; i < 70; i++) step(1'b1, "R4 up sweep");
    check(int'(wiper_pos) == TAPS - 1, "R4 top saturation", int'(wiper_pos), TAPS - 1);
    for (int i = 0; i < 110; i++) step(1'b0, "R4 down sweep");
    check(int'(wiper_pos) == 0, "R4 bottom saturation", int'(wiper_pos), 0);

    // R3: direction changes while selected.
    for (int i = 0; i < 24; i++) step((i % 3) != 0, "R3 mixed direction");

    // R2: rising edge of inc alone does not step.
    inc = 1'b0;
    up_dn = 1'b1;
    wait_cyc(6);
    exp_pos = model_step(exp_pos, 1'b1);
    check_pos("R2 falling edge steps");
    inc = 1'b1;
    wait_cyc(6);
    check_pos("R2 rising edge ignored");

    // R6: leave with inc low, no store.
    inc = 1'b0;
    wait_cyc(6);
    exp_pos = model_step(exp_pos, 1'b1);
    check_pos("R6 exit step");
    cs_n = 1'b1;
    wait_cyc(6);
    inc = 1'b1;
    wait_cyc(5);
    check(store_busy == 1'b0, "R6 no write busy", int'(store_busy), 0);
    check_pos("R2 inc rise with cs high");
    // R2: inc edges while deselected do nothing.
    for (int i = 0; i < 4; i++) begin
      inc = 1'b0;
      wait_cyc(5);
      inc = 1'b1;
      wait_cyc(5);
      check_pos("R2 deselected edges ignored");
    end
    power_cycle();
    exp_pos = INIT;
    wait_cyc(2);
    check_pos("R6 recall unchanged after no-store exit");
    wait_cyc(SETTLE + 4);

    // R5/R8: move to a known value and store with inc high.
    cs_n = 1'b0;
    wait_cyc(5);
    for (int i = 0; i < 5; i++) step(1'b1, "R3 up before store");
    saved = exp_pos;
    cs_n = 1'b1;
    busy_cnt = 0;
    fork
      begin
        for (int i = 0; i < 60; i++) begin
          @(negedge clk);
          if (store_busy) busy_cnt++;
        end
      end
      begin
        wait_cyc(6);
        cs_n = 1'b0;
        wait_cyc(3);
        up_dn = 1'b0;
        inc = 1'b0;
        wait_cyc(3);
        inc = 1'b1;
        wait_cyc(3);
        cs_n = 1'b1;
      end
    join
    check(busy_cnt == STORE, "R8 busy length", busy_cnt, STORE);
    check_pos("R8 activity during busy ignored");
    check(store_busy == 1'b0, "R8 no second write", int'(store_busy), 0);
    power_cycle();
    exp_pos = saved;
    wait_cyc(2);
    check_pos("R5 recall stored value");
    wait_cyc(SETTLE + 4);
    check(recall_done == 1'b1, "R1 ready after second power-up", int'(recall_done), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule